// File: doc/BRIEF.md
# Three-State Snooping Write-Back Cache Controller

This block is a small direct-mapped write-back cache that keeps its lines coherent with other caches on one shared bus in front of main memory. Each line holds one data word, a tag and a coherence state. The state is Invalid, Clean or Dirty. Clean means the line may be shared and can only be read. Dirty means this cache has the only copy, the copy is the newest one, and it may be written. The CPU side takes one read or write at a time. It sees a one-cycle `cpu_done` pulse when the access finishes, and read data is valid on `cpu_rdata` during that pulse.

Any access that cannot finish locally raises `bus_req`. The access then waits for `bus_gnt`. From the grant until completion the controller keeps the bus and runs its whole sequence without a gap. That sequence is an optional writeback of a dirty victim, then a read-miss or write-miss command, and, for a miss, the fill from `bus_rvalid`/`bus_rdata`. While it waits for the grant it keeps answering snoops, and it looks at the line again when the grant arrives. A snooped miss to one of its Dirty lines is answered in the same cycle on `snp_supply`/`snp_data`, so the bus can feed the requester and update memory.

Bus command encoding on `bus_cmd` and `snp_cmd`: 0 none, 1 read-miss, 2 write-miss, 3 writeback. A line is selected by the low `IDX_W` address bits, and the tag is the rest of the address.

Top module: `coh3_cache`

## Requirements
- R1: After reset every line is Invalid. `bus_req`, `cpu_done`, `snp_supply` are 0 and `bus_cmd` is 0, so the first read of any address goes to the bus.
- R2: A CPU read that hits a Clean or Dirty line completes with the stored word, with `bus_req` never raised. `cpu_done` is a single-cycle pulse.
- R3: A CPU write that hits a Dirty line completes without any bus request.
- R4: A CPU write that hits a Clean line requests the bus and places one write-miss (2) for that address. It completes without waiting for `bus_rvalid`, and the line becomes Dirty.
- R5: A CPU read miss issues read-miss (1) and fills the line Clean with `bus_rdata`. A CPU write miss issues write-miss (2), waits for `bus_rvalid`, and installs the CPU word as Dirty.
- R6: A miss whose victim line is Dirty first places writeback (3) with the victim's full address and data for one cycle, followed directly by the miss command.
- R7: A snooped read-miss (1) whose address hits a Dirty line raises `snp_supply` in that cycle with the line's word on `snp_data`. The line becomes Clean, so a later CPU write needs a bus write-miss.
- R8: A snooped write-miss (2) hitting a valid line invalidates it. If the line was Dirty, its word is supplied in the same cycle. A snoop whose tag does not match changes nothing.
- R9: Snooped commands are ignored while `bus_gnt` is high, because this cache is then the bus owner.
- R10: While waiting for grant the controller stalls the CPU with `bus_req` high and still services snoops. On grant it re-checks the line, so a Clean line invalidated while waiting becomes a full write miss that waits for `bus_rvalid`.
- R11: `bus_req` stays high from the request until completion, and a command other than 0 appears only while `bus_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | DATA_W | CPU write word |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | Command placed on the bus |
| bus_addr | output | ADDR_W | Address of the command |
| bus_wdata | output | DATA_W | Writeback data |
| bus_rvalid | input | 1 | Fill data valid for a pending miss |
| bus_rdata | input | DATA_W | Fill data |
| snp_valid | input | 1 | Snooped command present |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped address |
| snp_supply | output | 1 | This cache supplies the Dirty block |
| snp_data | output | DATA_W | Supplied block |

## Verification
A vector walk drives reads and writes that land on each line state. A cold read, a repeated read and an upgrade write are separated by which bus command appears, if any. A conflicting read to the same index with a Dirty victim must show a writeback before the read-miss, and a reread of the evicted address proves memory received the data. Directed snoops of each command against Dirty, Clean and non-matching lines are told apart by `snp_supply` and by the bus command that a following CPU access needs. A snoop arriving while a write waits for grant is detected because the access then waits for fill data instead of completing as an upgrade.

// File: rtl/coh3_cache.sv
module coh3_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rvalid,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] L_INV = 2'd0, L_CLN = 2'd1, L_DRT = 2'd2;
  localparam logic [1:0] C_NONE = 2'd0, C_RM = 2'd1, C_WM = 2'd2, C_WB = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_WB, S_MISS, S_UPG} fsm_t;
  fsm_t st;

  logic [1:0]        lst_q [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];
  logic              rq_we, done_q;
  logic [ADDR_W-1:0] rq_addr;
  logic [DATA_W-1:0] rq_wd, rdata_q;

  wire              idle = (st == S_IDLE);
  wire [ADDR_W-1:0] la   = idle ? cpu_addr : rq_addr;
  wire              lwe  = idle ? cpu_we : rq_we;
  wire [DATA_W-1:0] lwd  = idle ? cpu_wdata : rq_wd;
  wire [IDX_W-1:0]  li   = la[IDX_W-1:0];
  wire [TAG_W-1:0]  lt   = la[ADDR_W-1:IDX_W];
  wire              hit  = (lst_q[li] != L_INV) && (tag_q[li] == lt);
  wire              local_ok = hit && (!lwe || lst_q[li] == L_DRT);

  wire [IDX_W-1:0]  si      = snp_addr[IDX_W-1:0];
  wire              snp_act = snp_valid && !bus_gnt && (snp_cmd == C_RM || snp_cmd == C_WM);
  wire              snp_hit = snp_act && (lst_q[si] != L_INV) && (tag_q[si] == snp_addr[ADDR_W-1:IDX_W]);
  wire              cpu_take = idle && cpu_req && !done_q && !snp_act;

  assign snp_supply = snp_hit && (lst_q[si] == L_DRT);
  assign snp_data   = dat_q[si];
  assign bus_req    = !idle;
  assign bus_cmd    = (st == S_WB)   ? C_WB :
                      (st == S_MISS) ? (rq_we ? C_WM : C_RM) :
                      (st == S_UPG)  ? C_WM : C_NONE;
  assign bus_addr   = (st == S_WB) ? {tag_q[li], li} : rq_addr;
  assign bus_wdata  = (st == S_WB) ? dat_q[li] : '0;
  assign cpu_rdata  = rdata_q;
  assign cpu_done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      done_q  <= 1'b0;
      rdata_q <= '0;
      rq_we   <= 1'b0;
      rq_addr <= '0;
      rq_wd   <= '0;
      for (int i = 0; i < LINES; i++) begin
        lst_q[i] <= L_INV;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      if (snp_hit) lst_q[si] <= (snp_cmd == C_RM) ? L_CLN : L_INV;
      case (st)
        S_IDLE: if (cpu_take) begin
          rq_we   <= cpu_we;
          rq_addr <= cpu_addr;
          rq_wd   <= cpu_wdata;
          if (local_ok) begin
            if (cpu_we) dat_q[li] <= cpu_wdata;
            else        rdata_q   <= dat_q[li];
            done_q <= 1'b1;
          end else st <= S_WAIT;
        end
        S_WAIT: if (bus_gnt) begin
          if (local_ok) begin
            if (lwe) dat_q[li] <= lwd;
            else     rdata_q   <= dat_q[li];
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (hit)                st <= S_UPG;
          else if (lst_q[li] == L_DRT)     st <= S_WB;
          else                             st <= S_MISS;
        end
        S_WB: begin
          lst_q[li] <= L_INV;
          st        <= S_MISS;
        end
        S_MISS: if (bus_rvalid) begin
          tag_q[li] <= lt;
          if (rq_we) begin
            dat_q[li] <= rq_wd;
            lst_q[li] <= L_DRT;
          end else begin
            dat_q[li] <= bus_rdata;
            rdata_q   <= bus_rdata;
            lst_q[li] <= L_CLN;
          end
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        S_UPG: begin
          dat_q[li] <= rq_wd;
          lst_q[li] <= L_DRT;
          done_q    <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) cpu_done |=> !cpu_done); // R2
  AST_UPG_DIRTY:      assert property (@(posedge clk) disable iff (!rst_n) (st == S_UPG) |=> lst_q[$past(li)] == L_DRT); // R4
  AST_WB_THEN_MISS:   assert property (@(posedge clk) disable iff (!rst_n) (bus_cmd == C_WB) |=> (bus_cmd == C_RM || bus_cmd == C_WM)); // R6
  AST_SUPPLY_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) snp_supply |=> lst_q[$past(si)] != L_DRT); // R7
  AST_OWNER_SILENT:   assert property (@(posedge clk) disable iff (!rst_n) bus_gnt |-> !snp_supply); // R9
  AST_WAIT_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (st == S_WAIT && !bus_gnt) |=> bus_req); // R10
  AST_CMD_GRANTED:    assert property (@(posedge clk) disable iff (!rst_n) (bus_cmd != C_NONE) |-> bus_gnt); // R11
endmodule

// File: tb/tb_coh3_cache.sv
module tb_coh3_cache;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [7:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        cpu_done, bus_req;
  logic        bus_gnt = 0, bus_rvalid = 0;
  logic [1:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata = '0;
  logic        snp_valid = 0;
  logic [1:0]  snp_cmd = '0;
  logic [7:0]  snp_addr = '0;
  logic        snp_supply;
  logic [15:0] snp_data;

  coh3_cache dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [15:0] mem [256];
  logic [15:0] ref_d [256];
  logic [1:0]  seen_cmd;
  logic        seen_wb, done_ok, cmd_wo_gnt = 1'b0;
  logic [7:0]  wb_addr;
  logic [15:0] wb_data, got_rd, sdat;
  logic        sup;

  task automatic chk(input logic ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [7:0] a, input logic [15:0] wd);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    seen_cmd = 0; seen_wb = 0; done_ok = 0;
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      if (bus_cmd != 0 && !bus_gnt) cmd_wo_gnt = 1'b1;
      if (bus_cmd == 2'd3) begin
        seen_wb = 1; wb_addr = bus_addr; wb_data = bus_wdata; mem[bus_addr] = bus_wdata;
      end else if (bus_cmd != 0) begin
        if (seen_cmd == 0) seen_cmd = bus_cmd;
        bus_rvalid = 1; bus_rdata = mem[bus_addr];
      end else bus_rvalid = 0;
      bus_gnt = bus_req;
      if (cpu_done) begin got_rd = cpu_rdata; done_ok = 1; break; end
    end
    cpu_req = 0; bus_gnt = 0; bus_rvalid = 0;
    if (!done_ok) chk(1'b0, "R11", "operation timed out", 0, 1);
    if (we) ref_d[a] = wd;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #1; sup = snp_supply; sdat = snp_data;
    @(negedge clk);
    snp_valid = 0;
  endtask

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  // {kind[3], we, addr[8], wdata[16], exp_cmd[2], exp_wb}
  localparam logic [30:0] VEC [10] = '{
    {3'd1, 1'b0, 8'h10, 16'h0000, 2'd1, 1'b0},
    {3'd2, 1'b0, 8'h10, 16'h0000, 2'd0, 1'b0},
    {3'd4, 1'b1, 8'h10, 16'hA1A1, 2'd2, 1'b0},
    {3'd3, 1'b1, 8'h10, 16'hB2B2, 2'd0, 1'b0},
    {3'd2, 1'b0, 8'h10, 16'h0000, 2'd0, 1'b0},
    {3'd6, 1'b0, 8'h20, 16'h0000, 2'd1, 1'b1},
    {3'd6, 1'b0, 8'h10, 16'h0000, 2'd1, 1'b0},
    {3'd5, 1'b1, 8'h31, 16'hC3C3, 2'd2, 1'b0},
    {3'd3, 1'b1, 8'h31, 16'hD4D4, 2'd0, 1'b0},
    {3'd2, 1'b0, 8'h31, 16'h0000, 2'd0, 1'b0}
  };

  initial begin
    #(8 * 20000);
    chk(1'b0, "R11", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'h1000 + 16'(i);
      ref_d[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_req && !cpu_done && bus_cmd == 0 && !snp_supply, "R1", "idle outputs after reset",
        {bus_req, cpu_done, bus_cmd, snp_supply}, 0);

    for (int v = 0; v < 10; v++) begin
      logic [30:0] e;
      e = VEC[v];
      cpu_op(e[27], e[26:19], e[18:3]);
      chk(seen_cmd == e[2:1], tag_of(e[30:28]), $sformatf("bus command, step %0d", v), seen_cmd, e[2:1]);
      chk(seen_wb == e[0], tag_of(e[30:28]), $sformatf("writeback seen, step %0d", v), seen_wb, e[0]);
      if (e[0])
        chk(wb_addr[1:0] == e[20:19] && wb_data == ref_d[wb_addr], "R6", "victim address/data",
            {wb_addr, wb_data}, {wb_addr, ref_d[wb_addr]});
      if (!e[27])
        chk(got_rd == ref_d[e[26:19]], tag_of(e[30:28]), $sformatf("read data, step %0d", v),
            got_rd, ref_d[e[26:19]]);
    end
    chk(!cmd_wo_gnt, "R11", "command only under grant", cmd_wo_gnt, 0);

    // R7: read-miss snoop on Dirty 0x31
    snoop(2'd1, 8'h31);
    chk(sup && sdat == 16'hD4D4, "R7", "dirty supply on read-miss", {sup, sdat}, {1'b1, 16'hD4D4});
    mem[8'h31] = sdat;
    cpu_op(1, 8'h31, 16'h4444);
    chk(seen_cmd == 2'd2, "R7", "line became Clean, write needs bus", seen_cmd, 2);

    // R8: write-miss snoop on Dirty and on Clean lines
    snoop(2'd2, 8'h31);
    chk(sup && sdat == 16'h4444, "R8", "dirty supply on write-miss", {sup, sdat}, {1'b1, 16'h4444});
    mem[8'h31] = sdat;
    cpu_op(0, 8'h31, 0);
    chk(seen_cmd == 2'd1 && got_rd == 16'h4444, "R8", "dirty line invalidated", {seen_cmd, got_rd}, {2'd1, 16'h4444});
    snoop(2'd2, 8'h10);
    chk(!sup, "R8", "clean line not supplied", sup, 0);
    cpu_op(0, 8'h10, 0);
    chk(seen_cmd == 2'd1, "R8", "clean line invalidated", seen_cmd, 1);

    // R10: snoop invalidates a Clean line while a write waits for grant
    cpu_op(0, 8'h22, 0);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h22; cpu_wdata = 16'h7777;
    repeat (3) @(negedge clk);
    chk(bus_req && !cpu_done, "R10", "stalled waiting for grant", {bus_req, cpu_done}, 2'b10);
    snp_valid = 1; snp_cmd = 2'd2; snp_addr = 8'h22;
    @(negedge clk);
    snp_valid = 0; bus_gnt = 1;
    @(negedge clk);
    chk(bus_cmd == 2'd2, "R10", "write-miss after grant", bus_cmd, 2);
    repeat (2) @(negedge clk);
    chk(!cpu_done && bus_cmd == 2'd2, "R10", "re-checked line waits for fill", {cpu_done, bus_cmd}, {1'b0, 2'd2});
    bus_rvalid = 1; bus_rdata = mem[8'h22];
    @(negedge clk);
    chk(cpu_done, "R10", "completes after fill", cpu_done, 1);
    cpu_req = 0; bus_gnt = 0; bus_rvalid = 0;
    ref_d[8'h22] = 16'h7777;

    // R9: snoop ignored while granted
    @(negedge clk);
    bus_gnt = 1; snp_valid = 1; snp_cmd = 2'd2; snp_addr = 8'h22;
    #1;
    chk(!snp_supply, "R9", "no supply while owner", snp_supply, 0);
    @(negedge clk);
    snp_valid = 0; bus_gnt = 0;
    cpu_op(0, 8'h22, 0);
    chk(seen_cmd == 0 && got_rd == 16'h7777, "R9", "line kept Dirty", {seen_cmd, got_rd}, {2'd0, 16'h7777});

    // R8: tag mismatch changes nothing
    snoop(2'd2, 8'h62);
    chk(!sup, "R8", "mismatch not supplied", sup, 0);
    cpu_op(1, 8'h22, 16'h8888);
    chk(seen_cmd == 0, "R8", "mismatch left line Dirty", seen_cmd, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule